// File: doc/BRIEF.md
# Eight-Channel Tracked Audio Delay Line

This block delays eight audio channels, arranged as four stereo pairs (A to D, left and right), by amounts held in a small write-only configuration file. A channel's delay is a coarse term counted in blocks of 16 samples plus a fine term counted in single samples. The coarse term is shared by two stereo pairs (A/B and C/D). The fine term belongs to one channel. Two tracking bits let a single register stand for several channels, so a uniform delay on all eight outputs needs only a few register writes.

Each frame strobe latches one sample per channel and the resolved delays. A small state machine then walks the channels one per clock. For each channel it stores the new sample at the write pointer of that channel's private circular region and fetches the delayed sample from behind it. The machine has three states. ST_IDLE waits for a strobe; the transition ST_IDLE to ST_RUN is taken on `frame_stb`. ST_RUN handles one channel per cycle; the transition ST_RUN to ST_DONE is taken after the last channel. ST_DONE advances the write pointer and pulses `out_valid`; the transition ST_DONE to ST_IDLE is unconditional. A fixed two-frame latency sits on top of every setting. `DEPTH` must be a power of two.

Top module: `tracked_delay_line`

## Requirements
- R1: After reset all delay settings and both tracking bits are zero, `out_valid` is low, `samp_out` is zero, and every buffered sample reads as zero.
- R2: Writes decode as follows. Address 0 sets the coarse delay of pairs A/B from data bits 11:0. Address 1 sets it for pairs C/D from bits 11:0. Addresses 2..9 set the fine delay from bits 3:0 for channels A-left, A-right, B-left, B-right, C-left, C-right, D-left, D-right in that order. Address 0xA sets the track-coarse bit from bit 0 and the track-fine bit from bit 1. Unused upper data bits are dropped.
- R3: With resolved delay D, the output of channel c for frame k equals that channel's input of frame k-2-D, with D = 16*coarse + fine. Channel c sits in `samp_in`/`samp_out` bits c*DW+DW-1 : c*DW, with c = 0 for A-left up to 7 for D-right.
- R4: With the track-coarse bit set, address 0's coarse value applies to all four pairs.
- R5: With the track-fine bit set, address 2's fine value applies to channels 0..3 and address 6's fine value applies to channels 4..7.
- R6: Any sum up to 65535 is accepted. A resolved delay above DEPTH-3 is clamped to DEPTH-3.
- R7: A write is first used at the next frame strobe. A write in the same cycle as a strobe is not seen by that frame.
- R8: Writes to addresses 0xB..0xF change no setting.
- R9: Changing a delay keeps buffered samples, so a shortened delay returns samples that were already stored.
- R10: `out_valid` pulses high for one cycle, NCH+1 clock edges after the edge that accepts the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |
| frame_stb | input | 1 | One-cycle frame strobe |
| samp_in | input | 8*DW | One input sample per channel |
| samp_out | output | 8*DW | One delayed sample per channel |
| out_valid | output | 1 | Output frame complete |

## Verification
A configuration write and a frame strobe can land on the same clock edge. The write updates the setting while the frame latches the resolved delays. The bench provokes this by asserting `cfg_we` together with `frame_stb`. It judges the output by expecting the old delay for that frame and the new delay from the next frame on. The bench predicts every channel's output from its own history of inputs and its own copy of the settings.

// File: rtl/dly_pkg.sv
`timescale 1ns/1ps
package dly_pkg;
    localparam int NUM_CH   = 8;
    localparam int COARSE_W = 12;
    localparam int FINE_W   = 4;
    localparam int CFG_AW   = 4;
    localparam int CFG_DW   = 16;
    localparam logic [CFG_AW-1:0] ADDR_COARSE_AB = 4'h0;
    localparam logic [CFG_AW-1:0] ADDR_COARSE_CD = 4'h1;
    localparam logic [CFG_AW-1:0] ADDR_FINE_LO   = 4'h2;
    localparam logic [CFG_AW-1:0] ADDR_FINE_HI   = 4'h9;
    localparam logic [CFG_AW-1:0] ADDR_TRACK     = 4'hA;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ring_state_t;
endpackage

// File: rtl/dly_cfg.sv
`timescale 1ns/1ps
module dly_cfg
    import dly_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [CFG_AW-1:0]           cfg_addr,
    input  logic [CFG_DW-1:0]           cfg_wdata,
    output logic [COARSE_W-1:0]         coarse_ab,
    output logic [COARSE_W-1:0]         coarse_cd,
    output logic [NUM_CH*FINE_W-1:0]    fine_all,
    output logic                        trk_coarse,
    output logic                        trk_fine
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_ab  <= '0;
            coarse_cd  <= '0;
            fine_all   <= '0;
            trk_coarse <= 1'b0;
            trk_fine   <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_addr == ADDR_COARSE_AB) begin
                coarse_ab <= cfg_wdata[COARSE_W-1:0];
            end else if (cfg_addr == ADDR_COARSE_CD) begin
                coarse_cd <= cfg_wdata[COARSE_W-1:0];
            end else if (cfg_addr >= ADDR_FINE_LO && cfg_addr <= ADDR_FINE_HI) begin
                fine_all[(32'(cfg_addr) - 32'(ADDR_FINE_LO))*FINE_W +: FINE_W]
                    <= cfg_wdata[FINE_W-1:0];
            end else if (cfg_addr == ADDR_TRACK) begin
                trk_coarse <= cfg_wdata[0];
                trk_fine   <= cfg_wdata[1];
            end
        end
    end

    assert_ignore_high_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr > ADDR_TRACK) |=>
            ($stable(coarse_ab) && $stable(coarse_cd) && $stable(fine_all)
             && $stable(trk_coarse) && $stable(trk_fine)));

    assert_coarse_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_COARSE_AB) |=>
            (coarse_ab == $past(cfg_wdata[COARSE_W-1:0])));

    assert_track_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_TRACK) |=>
            (trk_fine == $past(cfg_wdata[1]) && trk_coarse == $past(cfg_wdata[0])));
endmodule

// File: rtl/dly_resolve.sv
`timescale 1ns/1ps
module dly_resolve
    import dly_pkg::*;
#(
    parameter int AW    = 5,
    parameter int LIMIT = 29
) (
    input  logic [COARSE_W-1:0]       coarse_ab,
    input  logic [COARSE_W-1:0]       coarse_cd,
    input  logic [NUM_CH*FINE_W-1:0]  fine_all,
    input  logic                      trk_coarse,
    input  logic                      trk_fine,
    output logic [NUM_CH*AW-1:0]      eff_all
);
    localparam int TW = COARSE_W + 4;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam int PAIR_HI = (ch >= 4) ? 1 : 0;
        localparam int LEAD    = (ch / 4) * 4;
        logic [COARSE_W-1:0] coarse_sel;
        logic [FINE_W-1:0]   fine_sel;
        logic [TW-1:0]       total;

        always_comb begin
            if (trk_coarse || PAIR_HI == 0) coarse_sel = coarse_ab;
            else                            coarse_sel = coarse_cd;
            if (trk_fine) fine_sel = fine_all[LEAD*FINE_W +: FINE_W];
            else          fine_sel = fine_all[ch*FINE_W +: FINE_W];
            total = {coarse_sel, 4'b0000} + TW'(fine_sel);
            if (total > TW'(LIMIT)) eff_all[ch*AW +: AW] = AW'(LIMIT);
            else                    eff_all[ch*AW +: AW] = total[AW-1:0];
        end
    end
endmodule

// File: rtl/dly_ring.sv
`timescale 1ns/1ps
module dly_ring
    import dly_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 32,
    parameter int AW    = 5,
    parameter int LIMIT = 29
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_stb,
    input  logic [NUM_CH*DW-1:0]   samp_in,
    input  logic [NUM_CH*AW-1:0]   eff_in,
    output logic [NUM_CH*DW-1:0]   samp_out,
    output logic                   out_valid
);
    localparam int CW = $clog2(NUM_CH);

    ring_state_t             state, state_nx;
    logic [DW-1:0]           mem [NUM_CH][DEPTH];
    logic [NUM_CH*DW-1:0]    in_q;
    logic [NUM_CH*AW-1:0]    eff_q;
    logic [CW-1:0]           ch_q;
    logic [AW-1:0]           wptr;
    logic [DW-1:0]           cur_in;
    logic [AW-1:0]           cur_eff;
    logic [AW-1:0]           rd_addr;

    assign cur_in  = in_q[32'(ch_q)*DW +: DW];
    assign cur_eff = eff_q[32'(ch_q)*AW +: AW];
    assign rd_addr = wptr - cur_eff - AW'(2);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (frame_stb) state_nx = ST_RUN;
            ST_RUN:  if (ch_q == CW'(NUM_CH-1)) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q      <= '0;
            eff_q     <= '0;
            ch_q      <= '0;
            wptr      <= '0;
            samp_out  <= '0;
            out_valid <= 1'b0;
            for (int c = 0; c < NUM_CH; c++) begin
                for (int a = 0; a < DEPTH; a++) begin
                    mem[c][a] <= '0;
                end
            end
        end else begin
            out_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (frame_stb) begin
                        in_q  <= samp_in;
                        eff_q <= eff_in;
                        ch_q  <= '0;
                    end
                end
                ST_RUN: begin
                    mem[ch_q][wptr]                <= cur_in;
                    samp_out[32'(ch_q)*DW +: DW]   <= mem[ch_q][rd_addr];
                    ch_q                           <= ch_q + CW'(1);
                end
                ST_DONE: begin
                    wptr      <= wptr + AW'(1);
                    out_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    logic eff_in_ok;
    always_comb begin
        eff_in_ok = 1'b1;
        for (int c = 0; c < NUM_CH; c++) begin
            if (eff_in[c*AW +: AW] > AW'(LIMIT)) eff_in_ok = 1'b0;
        end
    end

    assert_delay_capped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eff_in_ok);

    assert_read_behind_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (rd_addr != wptr));

    assert_valid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_pointer_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (wptr == $past(wptr) + AW'(1)));

    assert_strobe_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && frame_stb) |=> (state == ST_RUN));
endmodule

// File: rtl/tracked_delay_line.sv
`timescale 1ns/1ps
module tracked_delay_line
    import dly_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [3:0]            cfg_addr,
    input  logic [15:0]           cfg_wdata,
    input  logic                  frame_stb,
    input  logic [8*DW-1:0]       samp_in,
    output logic [8*DW-1:0]       samp_out,
    output logic                  out_valid
);
    localparam int AW    = $clog2(DEPTH);
    localparam int LIMIT = DEPTH - 3;

    logic [COARSE_W-1:0]      coarse_ab, coarse_cd;
    logic [NUM_CH*FINE_W-1:0] fine_all;
    logic                     trk_coarse, trk_fine;
    logic [NUM_CH*AW-1:0]     eff_all;

    dly_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .coarse_ab  (coarse_ab),
        .coarse_cd  (coarse_cd),
        .fine_all   (fine_all),
        .trk_coarse (trk_coarse),
        .trk_fine   (trk_fine)
    );

    dly_resolve #(.AW(AW), .LIMIT(LIMIT)) u_resolve (
        .coarse_ab  (coarse_ab),
        .coarse_cd  (coarse_cd),
        .fine_all   (fine_all),
        .trk_coarse (trk_coarse),
        .trk_fine   (trk_fine),
        .eff_all    (eff_all)
    );

    dly_ring #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .LIMIT(LIMIT)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .samp_in    (samp_in),
        .eff_in     (eff_all),
        .samp_out   (samp_out),
        .out_valid  (out_valid)
    );
endmodule

// File: tb/tracked_delay_line_test.sv
`timescale 1ns/1ps
module tracked_delay_line_test;
    localparam int DW    = 16;
    localparam int DEPTH = 32;
    localparam int LIM   = DEPTH - 3;
    localparam int NCH   = 8;
    localparam int HMAX  = 512;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [3:0]      cfg_addr = '0;
    logic [15:0]     cfg_wdata = '0;
    logic            frame_stb = 1'b0;
    logic [8*DW-1:0] samp_in = '0;
    logic [8*DW-1:0] samp_out;
    logic            out_valid;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int fc = 0;
    int hist [NCH][HMAX];
    int sh_coarse [2];
    int sh_fine [NCH];
    int sh_trk;

    always #10 clk = ~clk;

    tracked_delay_line #(.DW(DW), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_stb(frame_stb), .samp_in(samp_in),
        .samp_out(samp_out), .out_valid(out_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_delay(input int ch);
        int c, f, t;
        c = (sh_trk[0] || ch < 4) ? sh_coarse[0] : sh_coarse[1];
        f = sh_trk[1] ? sh_fine[(ch / 4) * 4] : sh_fine[ch];
        t = 16 * c + f;
        return (t > LIM) ? LIM : t;
    endfunction

    function automatic void shadow_write(input int a, input int d);
        if (a == 0)                sh_coarse[0] = d & 12'hFFF;
        else if (a == 1)           sh_coarse[1] = d & 12'hFFF;
        else if (a >= 2 && a <= 9) sh_fine[a-2] = d & 4'hF;
        else if (a == 10)          sh_trk = d & 3;
    endfunction

    task automatic cfg_write(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        shadow_write(a, d);
    endtask

    // one frame, optionally with a write on the strobe cycle
    task automatic run_frame(input string req, input bit wr, input int a, input int d);
        int dl [NCH];
        @(negedge clk);
        for (int ch = 0; ch < NCH; ch++) begin
            hist[ch][fc] = ch * 4096 + (fc % 4096) + 1;
            samp_in[ch*DW +: DW] = 16'(hist[ch][fc]);
            dl[ch] = model_delay(ch);
        end
        frame_stb = 1'b1;
        if (wr) begin cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d); end
        @(posedge clk);
        @(negedge clk);
        frame_stb = 1'b0;
        cfg_we = 1'b0;
        if (wr) shadow_write(a, d);
        repeat (NCH) @(posedge clk);
        @(negedge clk);
        check("R10 valid not yet", int'(out_valid), 0);
        @(posedge clk);
        @(negedge clk);
        check("R10 valid timing", int'(out_valid), 1);
        for (int ch = 0; ch < NCH; ch++) begin
            int idx, ex;
            idx = fc - 2 - dl[ch];
            ex = (idx < 0) ? 0 : hist[ch][idx];
            check(req, int'(samp_out[ch*DW +: DW]), ex);
        end
        @(negedge clk);
        check("R10 valid pulse", int'(out_valid), 0);
        fc++;
    endtask

    task automatic t_reset;
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 samp_out", int'(samp_out != '0), 0);
        for (int i = 0; i < 3; i++) run_frame("R1 zero buffer", 1'b0, 0, 0);
    endtask

    task automatic t_latency;
        for (int i = 0; i < 4; i++) run_frame("R3 two-frame latency", 1'b0, 0, 0);
    endtask

    task automatic t_fine;
        cfg_write(2, 16'h00F3);
        for (int a = 3; a <= 9; a++) cfg_write(a, a + 2);
        for (int i = 0; i < 14; i++) run_frame("R2 fine delays", 1'b0, 0, 0);
    endtask

    task automatic t_coarse;
        for (int a = 2; a <= 9; a++) cfg_write(a, 0);
        cfg_write(0, 16'hF001);
        cfg_write(1, 0);
        for (int i = 0; i < 20; i++) run_frame("R3 coarse plus fine", 1'b0, 0, 0);
    endtask

    task automatic t_track_coarse;
        cfg_write(10, 1);
        cfg_write(3, 4);
        for (int i = 0; i < 20; i++) run_frame("R4 track coarse", 1'b0, 0, 0);
    endtask

    task automatic t_track_fine;
        cfg_write(10, 2);
        cfg_write(0, 0);
        cfg_write(2, 5);
        cfg_write(6, 9);
        cfg_write(7, 1);
        for (int i = 0; i < 12; i++) run_frame("R5 track fine", 1'b0, 0, 0);
    endtask

    task automatic t_saturate;
        cfg_write(10, 0);
        cfg_write(0, 16'hFFFF);
        cfg_write(2, 15);
        cfg_write(1, 2);
        for (int i = 0; i < 8; i++) run_frame("R6 clamp", 1'b0, 0, 0);
    endtask

    task automatic t_ignore;
        for (int a = 11; a <= 15; a++) cfg_write(a, 16'hFFFF);
        for (int i = 0; i < 4; i++) run_frame("R8 high address ignored", 1'b0, 0, 0);
    endtask

    task automatic t_shrink;
        cfg_write(0, 0);
        cfg_write(1, 0);
        for (int i = 0; i < 4; i++) run_frame("R9 shortened delay", 1'b0, 0, 0);
    endtask

    task automatic t_collide;
        cfg_write(4, 0);
        run_frame("R7 same-cycle write", 1'b1, 4, 6);
        run_frame("R7 next frame", 1'b0, 0, 0);
        run_frame("R7 next frame", 1'b0, 0, 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        sh_coarse[0] = 0; sh_coarse[1] = 0; sh_trk = 0;
        for (int i = 0; i < NCH; i++) sh_fine[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latency();
        t_fine();
        t_coarse();
        t_track_coarse();
        t_track_fine();
        t_saturate();
        t_ignore();
        t_shrink();
        t_collide();
        finish_run();
    end

    initial begin
        #(20 * 150000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end
endmodule